// File: doc/BRIEF.md
# Radix-4 Modular Butterfly for the Kyber Number Theoretic Transform

This block carries out one radix-4 butterfly over the prime field of order 3329 on every cycle. It takes four 12-bit coefficients and three 7-bit twiddle addresses. It returns four 12-bit results three cycles later. A controller outside the block is expected to stream coefficient groups from four read banks and write the four results into four write banks. That controller, the banks and the address sequencing are outside this block.

A mode bit travels with each operation. With the bit low, the butterfly runs two forward layers. Each layer multiplies by the twiddle first and then adds and subtracts. With the bit high, it runs two inverse layers. Each layer adds and subtracts first and then multiplies the difference by the twiddle. Sums and differences are shared, so each operation uses exactly four modular multipliers. A multiplier is a 12x12 product followed by Barrett reduction.

Twiddles come from an internal table. The forward and inverse halves of the table are computed at elaboration from the root 17. The bit-reversed twiddle order is held in the table itself, so the addresses the controller supplies are plain linear indices. Inverse results are not scaled by 1/n. A later pass does that scaling.

Top module: `ntt_r4_butterfly`

## Requirements
- R1: With `inv_mode`=0 and twiddles w0,w1,w2, the block first forms t=w0·a2, u=w0·a3, b0=a0+t, b2=a0−t, b1=a1+u, b3=a1−u. It then returns y0=b0+w1·b1, y1=b0−w1·b1, y2=b2+w2·b3, y3=b2−w2·b3. All arithmetic is mod 3329.
- R2: With `inv_mode`=1, the block first forms b0=a0+a1, b1=(a0−a1)·w1, b2=a2+a3, b3=(a2−a3)·w2. It then returns y0=b0+b2, y1=b1+b3, y2=(b0−b2)·w0, y3=(b1−b3)·w0. All arithmetic is mod 3329.
- R3: Twiddle wi is read at address `tw_addr[i]`. The forward entry at address k is 17^brv7(k) mod 3329. The inverse entry is 17^((256−brv7(k)) mod 256) mod 3329. Here brv7 reverses the 7 address bits.
- R4: When the inputs are below 3329, every output is in the range 0..3328.
- R5: `out_valid` rises exactly 3 cycles after `in_valid` is sampled high. A new operation is accepted on every cycle.
- R6: While `out_valid` is low, `y_out` keeps its previous value.
- R7: Asserting `rst_n` low clears every operation in flight, and `out_valid` stays low until new operations arrive.
- R8: A forward operation followed by an inverse operation on its outputs, with the same addresses, returns 4·a mod 3329. No 1/n factor is applied.
- R9: Each operation uses the mode sampled with it, so forward and inverse operations may alternate on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| inv_mode | input | 1 | 0 selects the forward butterfly, 1 selects the inverse butterfly |
| a_in | input | 48 | Coefficient i in bits [12i+11:12i], each below 3329 |
| tw_addr | input | 21 | Twiddle address i in bits [7i+6:7i] |
| out_valid | output | 1 | Result present on `y_out` |
| y_out | output | 48 | Result i in bits [12i+11:12i] |

## Verification
The case that is hardest to reach from the ports is the operand mux that lets the forward and inverse paths share the four multipliers. Only operations of different modes in adjacent pipeline stages show whether the mode reaches each stage intact. The stimulus therefore includes a burst that alternates the mode on every cycle, and a long random stream with random gaps. The table contents cannot be seen directly. Directed operations with unit coefficients turn every forward and inverse entry into an output value. Round trips, forward and then inverse, tie the two halves of the table together.

// File: rtl/ntt_r4_butterfly.sv
module ntt_r4_butterfly #(
  parameter int CW   = 12,
  parameter int AW   = 7,
  parameter int Q    = 3329,
  parameter int ROOT = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 inv_mode,
  input  logic [3:0][CW-1:0]   a_in,
  input  logic [2:0][AW-1:0]   tw_addr,
  output logic                 out_valid,
  output logic [3:0][CW-1:0]   y_out
);
  localparam int N     = 1 << AW;
  localparam int ORDER = 2 * N;
  localparam int BK    = 2 * CW;
  localparam logic [CW:0]     QA = (CW+1)'(Q);
  localparam logic [2*CW-1:0] QW = (2*CW)'(Q);
  localparam logic [CW:0]     BM = (CW+1)'((64'd1 << BK) / Q);

  function automatic int tw_pow(int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * ROOT) % Q;
    return r;
  endfunction

  function automatic int bitrev(int k);
    int r = 0;
    for (int i = 0; i < AW; i++) if (k[i]) r = r | (1 << (AW - 1 - i));
    return r;
  endfunction

  function automatic logic [CW-1:0] madd(logic [CW-1:0] x, logic [CW-1:0] y);
    logic [CW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= QA) s = s - QA;
    return s[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] msub(logic [CW-1:0] x, logic [CW-1:0] y);
    logic [CW:0] d;
    d = {1'b0, x} - {1'b0, y};
    if (x < y) d = d + QA;
    return d[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] mmul(logic [CW-1:0] x, logic [CW-1:0] y);
    logic [2*CW-1:0] p, tq, r;
    logic [3*CW:0]   pm;
    logic [CW:0]     t;
    p  = {{CW{1'b0}}, x} * {{CW{1'b0}}, y};
    pm = {{(CW+1){1'b0}}, p} * {{(2*CW){1'b0}}, BM};
    t  = pm[3*CW:BK];
    tq = {{(CW-1){1'b0}}, t} * QW;
    r  = p - tq;
    if (r >= QW) r = r - QW;
    return r[CW-1:0];
  endfunction

  logic [CW-1:0] rom_f [N];
  logic [CW-1:0] rom_i [N];

  for (genvar k = 0; k < N; k++) begin : g_rom
    localparam logic [CW-1:0] FW = CW'(tw_pow(bitrev(k)));
    localparam logic [CW-1:0] IV = CW'(tw_pow((ORDER - bitrev(k)) % ORDER));
    assign rom_f[k] = FW;
    assign rom_i[k] = IV;
  end

  logic                v1, v2, v3, inv1, inv2;
  logic [3:0][CW-1:0]  d1, d2, l1, l2;
  logic [2:0][CW-1:0]  t1;
  logic [CW-1:0]       ta, tb, pa, pb, pc, pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      d1   <= a_in;
      inv1 <= inv_mode;
      for (int i = 0; i < 3; i++)
        t1[i] <= inv_mode ? rom_i[tw_addr[i]] : rom_f[tw_addr[i]];
    end
    if (v1) begin
      d2   <= l1;
      inv2 <= inv1;
      ta   <= inv1 ? t1[0] : t1[1];
      tb   <= inv1 ? t1[0] : t1[2];
    end
    if (v2) y_out <= l2;
  end

  assign pa = mmul(inv1 ? msub(d1[0], d1[1]) : d1[2], inv1 ? t1[1] : t1[0]);
  assign pb = mmul(inv1 ? msub(d1[2], d1[3]) : d1[3], inv1 ? t1[2] : t1[0]);
  assign pc = mmul(inv2 ? msub(d2[0], d2[2]) : d2[1], ta);
  assign pd = mmul(inv2 ? msub(d2[1], d2[3]) : d2[3], tb);

  always_comb begin
    if (inv1) l1 = {pb, madd(d1[2], d1[3]), pa, madd(d1[0], d1[1])};
    else      l1 = {msub(d1[1], pb), msub(d1[0], pa), madd(d1[1], pb), madd(d1[0], pa)};
    if (inv2) l2 = {pd, pc, madd(d2[1], d2[3]), madd(d2[0], d2[2])};
    else      l2 = {msub(d2[2], pd), madd(d2[2], pd), msub(d2[0], pc), madd(d2[0], pc)};
  end

  assign out_valid = v3;
endmodule

// File: rtl/ntt_r4_butterfly_chk.sv
module ntt_r4_butterfly_chk #(
  parameter int CW = 12,
  parameter int Q  = 3329
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [3:0][CW-1:0] a_in,
  input logic               out_valid,
  input logic [3:0][CW-1:0] y_out
);
  logic [2:0] seen_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_v <= '0;
    else        seen_v <= {seen_v[1:0], in_valid};
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == seen_v[2]); // R5

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (y_out[0] < Q && y_out[1] < Q && y_out[2] < Q && y_out[3] < Q)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && seen_v[2] == 1'b0) |-> $stable(y_out)); // R6

  AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_in == '0) |-> ##3 (out_valid && y_out == '0)); // R1
endmodule

bind ntt_r4_butterfly ntt_r4_butterfly_chk #(.CW(CW), .Q(Q)) u_chk (.*);

// File: tb/test_ntt_r4_butterfly.sv
module test_ntt_r4_butterfly;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3329;

  logic clk = 0, rst_n = 0, in_valid = 0, inv_mode = 0;
  logic [3:0][11:0] a_in = '0;
  logic [2:0][6:0]  tw_addr = '0;
  logic out_valid;
  logic [3:0][11:0] y_out;

  ntt_r4_butterfly i_ntt_r4_butterfly (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [47:0] exp_q[$];
  int tag_q[$];
  logic [47:0] last_y;
  bit seen = 0;
  bit [2:0] hist = '0;

  task automatic chk(bit ok, int tag, string what, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int pw(int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * 17) % Q;
    return r;
  endfunction

  function automatic int brv(int k);
    int r = 0;
    for (int i = 0; i < 7; i++) if (k[i]) r = r | (1 << (6 - i));
    return r;
  endfunction

  // R3: table entries
  function automatic int twid(bit inv, int k);
    return inv ? pw((256 - brv(k)) % 256) : pw(brv(k));
  endfunction

  function automatic logic [47:0] model(bit inv, logic [3:0][11:0] a, logic [2:0][6:0] ad);
    int w0, w1, w2, x0, x1, x2, x3, b0, b1, b2, b3, t, y0, y1, y2, y3;
    w0 = twid(inv, int'(ad[0])); w1 = twid(inv, int'(ad[1])); w2 = twid(inv, int'(ad[2]));
    x0 = int'(a[0]); x1 = int'(a[1]); x2 = int'(a[2]); x3 = int'(a[3]);
    if (!inv) begin // R1
      t = (x2 * w0) % Q; b0 = (x0 + t) % Q; b2 = (x0 - t + Q) % Q;
      t = (x3 * w0) % Q; b1 = (x1 + t) % Q; b3 = (x1 - t + Q) % Q;
      t = (b1 * w1) % Q; y0 = (b0 + t) % Q; y1 = (b0 - t + Q) % Q;
      t = (b3 * w2) % Q; y2 = (b2 + t) % Q; y3 = (b2 - t + Q) % Q;
    end else begin // R2
      b0 = (x0 + x1) % Q; b1 = (((x0 - x1 + Q) % Q) * w1) % Q;
      b2 = (x2 + x3) % Q; b3 = (((x2 - x3 + Q) % Q) * w2) % Q;
      y0 = (b0 + b2) % Q; y2 = (((b0 - b2 + Q) % Q) * w0) % Q;
      y1 = (b1 + b3) % Q; y3 = (((b1 - b3 + Q) % Q) * w0) % Q;
    end
    return {12'(y3), 12'(y2), 12'(y1), 12'(y0)};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_valid == 1'b0, 7, "out_valid during reset", 48'(out_valid), 48'd0);
      hist = '0;
      exp_q.delete();
      tag_q.delete();
    end else begin
      if (hist[2] || out_valid)
        chk(out_valid == hist[2], 5, "out_valid timing", 48'(out_valid), 48'(hist[2]));
      if (out_valid && exp_q.size() > 0) begin
        logic [47:0] e;
        int tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(y_out == e, tg, "result", y_out, e);
        chk(y_out[0] < Q && y_out[1] < Q && y_out[2] < Q && y_out[3] < Q, 4,
            "range", y_out, 48'd0);
      end else if (!out_valid && seen)
        chk(y_out == last_y, 6, "hold while idle", y_out, last_y);
      if (out_valid) seen = 1;
      last_y = y_out;
      hist = {hist[1:0], in_valid};
    end
  end

  task automatic drive(bit inv, logic [3:0][11:0] a, logic [2:0][6:0] ad, int tag);
    @(posedge clk); #1;
    in_valid = 1; inv_mode = inv; a_in = a; tw_addr = ad;
    exp_q.push_back(model(inv, a, ad));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 0;
      a_in = 48'(i * 7919);
      inv_mode = ~inv_mode;
    end
  endtask

  function automatic logic [3:0][11:0] rnd_a();
    logic [3:0][11:0] r;
    for (int i = 0; i < 4; i++) r[i] = 12'($urandom % Q);
    return r;
  endfunction

  function automatic logic [2:0][6:0] rnd_ad();
    return {7'($urandom), 7'($urandom), 7'($urandom)};
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog expired: actual hung expected done");
    report();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    idle(2);

    // R1 R2: directed corners
    drive(0, '0, '0, 1);
    drive(1, '0, '0, 2);
    drive(0, {4{12'd3328}}, {3{7'd127}}, 1);
    drive(1, {4{12'd3328}}, {3{7'd127}}, 2);
    drive(0, {12'd3328, 12'd1, 12'd3328, 12'd1}, '0, 1);
    drive(1, {12'd0, 12'd3328, 12'd1, 12'd3328}, {7'd64, 7'd1, 7'd0}, 2);
    idle(5);

    // R3: every table entry brought to the outputs
    for (int k = 0; k < 128; k++) drive(0, {12'd0, 12'd1, 12'd0, 12'd0}, {3{7'(k)}}, 3);
    for (int k = 0; k < 128; k++) drive(1, {12'd0, 12'd0, 12'd0, 12'd1}, {3{7'(k)}}, 3);
    idle(5);

    // R9: mode alternates on consecutive cycles
    for (int i = 0; i < 40; i++) drive(i[0], rnd_a(), rnd_ad(), 9);
    idle(5);

    // R1 R2: random stream with gaps
    for (int i = 0; i < 400; i++) begin
      bit m;
      m = 1'($urandom);
      drive(m, rnd_a(), rnd_ad(), m ? 2 : 1);
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(5);

    // R8: forward then inverse gives 4a
    for (int i = 0; i < 20; i++) begin
      logic [3:0][11:0] a, f, e;
      logic [2:0][6:0] ad;
      a = rnd_a();
      ad = rnd_ad();
      drive(0, a, ad, 8);
      idle(4);
      f = y_out;
      drive(1, f, ad, 8);
      idle(4);
      for (int j = 0; j < 4; j++) e[j] = 12'((4 * int'(a[j])) % Q);
      chk(y_out == e, 8, "round trip", y_out, e);
    end

    // R7: reset with operations in flight
    drive(0, rnd_a(), rnd_ad(), 7);
    drive(1, rnd_a(), rnd_ad(), 7);
    @(posedge clk); #1;
    in_valid = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    idle(6);
    drive(0, rnd_a(), rnd_ad(), 7);
    idle(6);
    report();
  end
endmodule